// File: doc/BRIEF.md
# Stuck Reference Clock Detector

This block watches a set of reference clocks (two by default) against a feedback clock and raises a flag for any reference that has stopped toggling. All logic runs on one fast system clock. The reference clocks, the feedback clock and an alarm-clear input all arrive asynchronously. Each is passed through a multi-flop synchronizer. Edges are then found by comparing every new synchronized sample with the sample before it.

Each reference has its own counter. The counter advances on every feedback transition, rising or falling. Any transition of that reference returns its counter to zero. When a counter reaches the dead-edge limit, the reference's flag sets and stays set. The alarm-clear input is active low. A falling assertion of it is reduced to one clear pulse, so a reference that is still dead raises its flag again even while the input is held low. The system clock must run at least four times faster than the fastest monitored clock.

Top module: `stuck_ref_detector`

## Requirements
- R1: A reference that holds one level, high or low, across DEAD_EDGES (default 3) consecutive feedback transitions has its flag set, visible within five system clocks of the last such transition; with fewer transitions the flag stays clear.
- R2: Rising and falling feedback transitions both advance the count, so a feedback clock that only toggles is enough to detect a dead reference.
- R3: Any transition on a reference resets that reference's count to zero, so a flag only sets after DEAD_EDGES feedback transitions since the reference's last transition.
- R4: Flag bit i of ref_bad_o belongs to reference input bit i and is active high; one reference's activity never sets or clears another reference's flag.
- R5: Once set, a flag stays set while the alarm-clear input stays high, even after the reference starts toggling again.
- R6: A high-to-low change of alarm_clr_n_i produces exactly one clear pulse, which drops every flag for one cycle. A reference that is still dead sets its flag again while the input is held low. Releasing the input to high clears nothing.
- R7: The synchronous active-high reset clears every counter and every flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the fastest monitored clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_i | input | NUM_REF | Asynchronous reference clocks under watch |
| fb_clk_i | input | 1 | Asynchronous feedback clock whose transitions are counted |
| alarm_clr_n_i | input | 1 | Asynchronous active-low flag clear, one-shot per assertion |
| ref_bad_o | output | NUM_REF | Sticky dead-reference flags, bit i for reference i |

## Verification
The bench builds the block with its defaults: two references, a limit of three feedback transitions and two synchronizer stages. This small setting lets the bench sweep every lane, both stuck levels and every count of feedback transitions from zero to five. That covers both sides of the threshold. The bench computes the expected flag from the count alone, while the other lane is kept alive to show the lanes are independent. The same setting makes the count reset, the sticky flag, the held-low clear and the reset short, directed sequences with exact expected flag values.

// File: rtl/sdet_pkg.sv
`timescale 1ns/1ps
package sdet_pkg;

    // One synchronized signal as seen by the lane logic.
    typedef struct packed {
        logic level;
        logic toggled;
    } sample_t;

    // Counter width able to hold 0 .. limit.
    function automatic int unsigned count_width(input int unsigned limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/sdet_sync.sv
`timescale 1ns/1ps
module sdet_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < int'(STAGES); s++) chain_q[s] <= INIT;
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < int'(STAGES); s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sdet_edge.sv
`timescale 1ns/1ps
module sdet_edge
    import sdet_pkg::*;
#(
    parameter int unsigned WIDTH = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [WIDTH-1:0]    level_i,
    output sample_t [WIDTH-1:0] smp_o
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level_i;
    end

    for (genvar g = 0; g < int'(WIDTH); g++) begin : g_bit
        assign smp_o[g].level   = level_i[g];
        assign smp_o[g].toggled = level_i[g] ^ prev_q[g];
    end
endmodule

// File: rtl/sdet_oneshot.sv
`timescale 1ns/1ps
module sdet_oneshot (
    input  logic clk,
    input  logic rst,
    input  logic arm_n_i,
    output logic pulse_o
);
    logic arm_prev_q;

    always_ff @(posedge clk) begin
        if (rst) arm_prev_q <= 1'b1;
        else     arm_prev_q <= arm_n_i;
    end

    // Only the high-to-low change yields a pulse.
    assign pulse_o = arm_prev_q & ~arm_n_i;
endmodule

// File: rtl/sdet_lane.sv
`timescale 1ns/1ps
module sdet_lane #(
    parameter int unsigned DEAD_EDGES = 3,
    parameter int unsigned CNT_W      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tog_i,
    input  logic             fb_tog_i,
    input  logic             clr_i,
    output logic             bad_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DEAD_EDGES);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             bad_q, bad_d;
    logic             hit;

    always_comb begin
        cnt_d = cnt_q;
        if (ref_tog_i)
            cnt_d = '0;
        else if (fb_tog_i && (cnt_q != LIMIT))
            cnt_d = cnt_q + 1'b1;
        hit   = (cnt_d == LIMIT);
        bad_d = clr_i ? 1'b0 : (bad_q | hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            bad_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            bad_q <= bad_d;
        end
    end

    assign bad_o = bad_q;
    assign cnt_o = cnt_q;
endmodule

// File: rtl/stuck_ref_detector.sv
`timescale 1ns/1ps
module stuck_ref_detector
    import sdet_pkg::*;
#(
    parameter int unsigned NUM_REF     = 2,
    parameter int unsigned DEAD_EDGES  = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REF-1:0] ref_clk_i,
    input  logic               fb_clk_i,
    input  logic               alarm_clr_n_i,
    output logic [NUM_REF-1:0] ref_bad_o
);
    localparam int unsigned CNT_W  = count_width(DEAD_EDGES);
    localparam int unsigned CLK_NB = NUM_REF + 1;

    logic [CLK_NB-1:0]          clk_sync;
    sample_t [CLK_NB-1:0]       clk_smp;
    logic                       alarm_sync;
    logic                       clr_pulse;
    logic [NUM_REF-1:0]         ref_tog;
    logic                       fb_tog;
    logic [NUM_REF*CNT_W-1:0]   cnt_flat;

    sdet_sync #(.WIDTH(CLK_NB), .STAGES(SYNC_STAGES), .INIT('0)) u_clk_sync (
        .clk(clk), .rst(rst), .async_i({fb_clk_i, ref_clk_i}), .sync_o(clk_sync)
    );

    sdet_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .INIT(1'b1)) u_alarm_sync (
        .clk(clk), .rst(rst), .async_i(alarm_clr_n_i), .sync_o(alarm_sync)
    );

    sdet_edge #(.WIDTH(CLK_NB)) u_edge (
        .clk(clk), .rst(rst), .level_i(clk_sync), .smp_o(clk_smp)
    );

    sdet_oneshot u_oneshot (
        .clk(clk), .rst(rst), .arm_n_i(alarm_sync), .pulse_o(clr_pulse)
    );

    assign fb_tog = clk_smp[NUM_REF].toggled;

    for (genvar g = 0; g < int'(NUM_REF); g++) begin : g_lane
        assign ref_tog[g] = clk_smp[g].toggled;
        sdet_lane #(.DEAD_EDGES(DEAD_EDGES), .CNT_W(CNT_W)) u_lane (
            .clk(clk), .rst(rst),
            .ref_tog_i(ref_tog[g]), .fb_tog_i(fb_tog), .clr_i(clr_pulse),
            .bad_o(ref_bad_o[g]), .cnt_o(cnt_flat[g*CNT_W +: CNT_W])
        );
    end
endmodule

// File: rtl/sdet_checker.sv
`timescale 1ns/1ps
module sdet_checker #(
    parameter int unsigned NUM_REF    = 2,
    parameter int unsigned CNT_W      = 2,
    parameter int unsigned DEAD_EDGES = 3
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     clr_pulse,
    input logic [NUM_REF-1:0]       ref_tog,
    input logic [NUM_REF-1:0]       bad,
    input logic [NUM_REF*CNT_W-1:0] cnt_flat
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DEAD_EDGES);

    p_reset_clears_r7: assert property (@(posedge clk) rst |=> (bad == '0));

    p_clear_drops_r6: assert property (@(posedge clk) disable iff (rst)
        clr_pulse |=> (bad == '0));

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        clr_pulse |=> !clr_pulse);

    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        !clr_pulse |=> ((bad & $past(bad)) == $past(bad)));

    for (genvar g = 0; g < int'(NUM_REF); g++) begin : g_lane_chk
        p_set_at_limit_r1: assert property (@(posedge clk) disable iff (rst)
            $rose(bad[g]) |-> (cnt_flat[g*CNT_W +: CNT_W] == LIMIT));

        p_edge_zeroes_r3: assert property (@(posedge clk) disable iff (rst)
            ref_tog[g] |=> (cnt_flat[g*CNT_W +: CNT_W] == '0));
    end
endmodule

bind stuck_ref_detector sdet_checker #(
    .NUM_REF(NUM_REF), .CNT_W(CNT_W), .DEAD_EDGES(DEAD_EDGES)
) u_chk (
    .clk(clk), .rst(rst), .clr_pulse(clr_pulse),
    .ref_tog(ref_tog), .bad(ref_bad_o), .cnt_flat(cnt_flat)
);

// File: tb/tb_stuck_ref_detector.sv
`timescale 1ns/1ps
module tb_stuck_ref_detector;
    localparam int NREF = 2;
    localparam int DEAD = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NREF-1:0] ref_clk = '0;
    logic            fb_clk = 1'b0;
    logic            alarm_n = 1'b1;
    logic [NREF-1:0] bad;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    stuck_ref_detector #(.NUM_REF(NREF), .DEAD_EDGES(DEAD), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .ref_clk_i(ref_clk), .fb_clk_i(fb_clk),
        .alarm_clr_n_i(alarm_n), .ref_bad_o(bad)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // One feedback transition, then toggle the references in keep_mask.
    task automatic fb_step(input logic [NREF-1:0] keep_mask);
        fb_clk = ~fb_clk;
        step(4);
        ref_clk = ref_clk ^ keep_mask;
        step(4);
    endtask

    task automatic alarm_pulse();
        alarm_n = 1'b0;
        step(4);
        alarm_n = 1'b1;
        step(4);
    endtask

    initial begin
        step(3);
        check("R7 reset lane0", bad[0], 1'b0);
        check("R7 reset lane1", bad[1], 1'b0);
        rst = 1'b0;
        step(4);

        // Sweep: lane, stuck level, number of feedback transitions.
        for (int lane = 0; lane < NREF; lane++) begin
            for (int lvl = 0; lvl < 2; lvl++) begin
                for (int n = 0; n <= 5; n++) begin
                    logic [NREF-1:0] other;
                    other = '1;
                    other[lane] = 1'b0;
                    ref_clk[lane] = ~lvl[0];
                    step(4);
                    ref_clk[lane] = lvl[0];
                    step(4);
                    ref_clk = ref_clk ^ other;
                    step(4);
                    alarm_pulse();
                    check("R6 clear before trial", |bad, 1'b0);
                    for (int k = 0; k < n; k++) fb_step(other);
                    check($sformatf("R1 R2 lane%0d lvl%0d n%0d", lane, lvl, n),
                          bad[lane], (n >= DEAD) ? 1'b1 : 1'b0);
                    check($sformatf("R4 other lane of %0d", lane),
                          bad[1-lane], 1'b0);
                end
            end
        end

        // R3: a reference transition restarts the count.
        ref_clk[0] = ~ref_clk[0];
        step(4);
        ref_clk[1] = ~ref_clk[1];
        step(4);
        alarm_pulse();
        fb_step(2'b10);
        fb_step(2'b10);
        ref_clk[0] = ~ref_clk[0];
        step(4);
        fb_step(2'b10);
        fb_step(2'b10);
        check("R3 restart not yet bad", bad[0], 1'b0);
        fb_step(2'b10);
        check("R3 bad after limit since restart", bad[0], 1'b1);

        // R5: flag stays set once the reference resumes.
        for (int k = 0; k < 6; k++) fb_step(2'b11);
        check("R5 sticky lane0", bad[0], 1'b1);
        check("R4 live lane1 clear", bad[1], 1'b0);

        // R6: held-low clear re-flags a dead reference.
        for (int k = 0; k < DEAD; k++) fb_step(2'b10);
        begin
            bit saw_low;
            saw_low = 0;
            alarm_n = 1'b0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (bad[0] == 1'b0) saw_low = 1;
            end
            check("R6 clear pulse seen", saw_low, 1'b1);
            check("R6 dead lane re-flagged while held", bad[0], 1'b1);
            check("R6 live lane stays clear", bad[1], 1'b0);
            alarm_n = 1'b1;
            step(6);
            check("R6 release does not clear", bad[0], 1'b1);
        end

        // R7: reset clears a set flag.
        rst = 1'b1;
        step(2);
        check("R7 reset clears flag", bad[0], 1'b0);
        rst = 1'b0;
        step(2);
        check("R7 stays clear after reset", bad[0], 1'b0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule